// File: doc/BRIEF.md
# Prescaled Ten-Bit Pulse-Width Modulator

This block produces one pulse-width modulated output from a free-running 8-bit period timer. A prescaler sits in front of the timer. A two-bit sub-count below each timer tick splits the tick into four equal slots. The 8-bit timer and the two sub-count bits together form a 10-bit position within the period. A 10-bit duty word is compared against that position. The duty word is built from an 8-bit high part and a 2-bit low part. The low part moves the falling edge in quarter-tick steps. With the prescaler at its smallest setting, a quarter tick is one clock. The output is high while the position is below the active duty.

Each period starts when the timer passes the value on `periodTop`. At that point the duty word presented on the inputs is copied into an active latch. A change to the duty inputs therefore never alters a period already in progress. When `enable` is low, all counters are cleared and the active duty is zeroed. After `enable` rises again, the first full period is low and normal pulses begin at the first boundary.

Top module: `prescaled_pwm`

## Requirements
- R1: During reset and after it is released, `pwmOut` is low. With `enable` high across the release, the first rise of `pwmOut` comes 4×(periodTop+1)×prescale clocks after the release.
- R2: `prescaleSel` encodes the prescale ratio: 0 gives 1, 1 gives 4, and 2 or 3 give 16. The output period is 4×(periodTop+1)×prescale clocks.
- R3: The duty value is {dutyHigh, dutyLow}. When this value D is nonzero, `pwmOut` goes high in the first clock of each period and stays high for D×prescale clocks.
- R4: When the duty value is zero, `pwmOut` stays low for the whole period.
- R5: When D is at least 4×(periodTop+1), `pwmOut` stays high without a break across successive periods.
- R6: A change to `dutyHigh` or `dutyLow` in the middle of a period leaves that period's high time unchanged. The change takes effect from the next period. `pwmOut` rises only in the clock right after a period boundary.
- R7: One clock after `enable` is sampled low, `pwmOut` is low, and it stays low while `enable` is low. After `enable` returns high, the first period is fully low, and `pwmOut` first rises 4×(periodTop+1)×prescale clocks after the first enabled edge.
- R8: Each step of `dutyLow` changes the high time by one prescale unit, so with prescale 1 the width resolves to a single clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control. Low clears the counters and forces the output low |
| prescaleSel | input | 2 | Prescale ratio select (0 gives 1, 1 gives 4, 2 or 3 give 16) |
| periodTop | input | 8 | Last timer value of each period |
| dutyHigh | input | 8 | Upper eight bits of the duty word |
| dutyLow | input | 2 | Lower two bits of the duty word |
| pwmOut | output | 1 | Modulated output |

## Verification
Two functions can meet in one cycle: the duty compare ending the pulse, and the period boundary starting the next pulse. These collide when the duty is one below, equal to, or above the full count of the period. The bench provokes this with duty values set to one less than 4×(periodTop+1), to exactly that value, and to the maximum code. It judges the result by counting high clocks. A duty one below the full count must give a single low clock per period. The larger duties must give an output with no gap at all. A second collision is a duty rewrite during a live period. It is judged by measuring the high time of that period and of the next one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int TIMER_W = 8;
  localparam int SUB_W   = 2;
  localparam int DUTY_W  = TIMER_W + SUB_W;
  localparam int MAX_PRE_LOG2 = 4;
  localparam int PRE_W   = SUB_W + MAX_PRE_LOG2;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // hold everything at zero
    logic tick;   // last clock of a timer tick
    logic wrap;   // last clock of a period
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int SubW = SUB_W,
  parameter int PreW = PRE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [1:0]      prescaleSel,
  input  logic            timerAtTop,
  output pwmStrobes_t     strobes,
  output logic [SubW-1:0] subCount
);
  localparam int SHIFT_MID = 2;
  localparam int SHIFT_MAX = PreW - SubW;

  logic [PreW-1:0] preCnt;
  logic [PreW-1:0] preLimit;
  int unsigned     shiftAmt;
  logic            tickEnd;

  // ratio select: shift of the sub-count field inside the prescale counter
  always_comb begin
    unique case (prescaleSel)
      2'd0:    shiftAmt = 0;
      2'd1:    shiftAmt = SHIFT_MID;
      default: shiftAmt = SHIFT_MAX;
    endcase
    preLimit = PreW'((1 << (SubW + shiftAmt)) - 1);
  end

  assign tickEnd  = enable && (preCnt >= preLimit);
  assign subCount = SubW'(preCnt >> shiftAmt);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) preCnt <= '0;
    else if (tickEnd)     preCnt <= '0;
    else                  preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobes.clear = !enable;
    strobes.tick  = tickEnd;
    strobes.wrap  = tickEnd && timerAtTop;
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int TimerW = TIMER_W,
  parameter int SubW   = SUB_W,
  localparam int DutyW = TimerW + SubW
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobes_t       strobes,
  input  logic [SubW-1:0]   subCount,
  input  logic [TimerW-1:0] periodTop,
  input  logic [DutyW-1:0]  dutyIn,
  output logic              timerAtTop,
  output logic [TimerW-1:0] timerVal,
  output logic              pwmOut
);
  logic [TimerW-1:0] timer;
  logic [DutyW-1:0]  dutyActive;
  logic [DutyW-1:0]  position;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      timer      <= '0;
      dutyActive <= '0;
    end else if (strobes.wrap) begin
      timer      <= '0;
      dutyActive <= dutyIn;   // buffered duty enters at the boundary
    end else if (strobes.tick) begin
      timer      <= timer + 1'b1;
    end
  end

  assign timerAtTop = (timer == periodTop);
  assign timerVal   = timer;
  assign position   = {timer, subCount};
  assign pwmOut     = (position < dutyActive);
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         prescaleSel,
  input  logic [TIMER_W-1:0] periodTop,
  input  logic [TIMER_W-1:0] dutyHigh,
  input  logic [SUB_W-1:0]   dutyLow,
  output logic               pwmOut
);
  pwmStrobes_t        strobes;
  logic [SUB_W-1:0]   subCount;
  logic               timerAtTop;
  logic [TIMER_W-1:0] timerNow;
  logic               wrapEvt;

  assign wrapEvt = strobes.wrap;

  pwm_ctrl #(.SubW(SUB_W), .PreW(PRE_W)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .prescaleSel(prescaleSel),
    .timerAtTop(timerAtTop), .strobes(strobes), .subCount(subCount)
  );

  pwm_datapath #(.TimerW(TIMER_W), .SubW(SUB_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .subCount(subCount),
    .periodTop(periodTop), .dutyIn({dutyHigh, dutyLow}),
    .timerAtTop(timerAtTop), .timerVal(timerNow), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/prescaled_pwm_checker.sv
module prescaled_pwm_checker
  import pwm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic [DUTY_W-1:0]  dutyIn,
  input logic               wrapEvt,
  input logic [TIMER_W-1:0] timerNow,
  input logic               pwmOut
);
  a_r7_low_while_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);

  a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && dutyIn == '0) |=> !pwmOut);

  a_r3_high_after_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && dutyIn != '0) |=> pwmOut);

  a_r6_rise_only_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(wrapEvt));

  a_r2_timer_restart: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (timerNow == '0));

  a_r1_low_in_reset: assert property (@(posedge clk)
    !rstN |=> !pwmOut);
endmodule

bind prescaled_pwm prescaled_pwm_checker chk (
  .clk(clk), .rstN(rstN), .enable(enable), .dutyIn({dutyHigh, dutyLow}),
  .wrapEvt(wrapEvt), .timerNow(timerNow), .pwmOut(pwmOut)
);

// File: tb/prescaled_pwm_test.sv
module prescaled_pwm_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LIMIT = 20000;
  // columns: sel, periodTop, dutyHigh, dutyLow, high clocks, period clocks
  localparam int VEC [6][6] = '{
    '{0, 9, 5, 1, 21, 40},
    '{1, 4, 2, 3, 44, 80},
    '{2, 2, 1, 0, 64, 192},
    '{3, 1, 0, 2, 32, 128},
    '{0, 0, 0, 1, 1, 4},
    '{0, 9, 9, 3, 39, 40}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] prescaleSel = '0;
  logic [7:0] periodTop = '0;
  logic [7:0] dutyHigh = '0;
  logic [1:0] dutyLow = '0;
  logic       pwmOut;

  int checks = 0;
  int fails = 0;
  int firstLow, highCnt, periodCnt, cnt;

  always #2 clk = ~clk;

  prescaled_pwm uut (
    .clk(clk), .rstN(rstN), .enable(enable), .prescaleSel(prescaleSel),
    .periodTop(periodTop), .dutyHigh(dutyHigh), .dutyLow(dutyLow),
    .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic setup(input int sel, input int per, input int dh, input int dl);
    prescaleSel = 2'(sel);
    periodTop   = 8'(per);
    dutyHigh    = 8'(dh);
    dutyLow     = 2'(dl);
  endtask

  task automatic waitRise(output int lows);
    lows = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (pwmOut) return;
      lows++;
    end
    lows = -1;
  endtask

  task automatic countHigh(output int highs);
    highs = 1;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (!pwmOut) return;
      highs++;
    end
    highs = -1;
  endtask

  // restart from disabled, then measure the first low time, high time and period
  task automatic measure(output int fl, output int hc, output int pc);
    int lows;
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitRise(fl);
    countHigh(hc);
    waitRise(lows);
    pc = hc + lows + 1;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    // R1: reset behaviour
    setup(0, 9, 5, 1);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1 low in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    waitRise(firstLow);
    check(firstLow == 39, "R1 first rise after reset", firstLow, 39);
    countHigh(highCnt);
    check(highCnt == 21, "R1 R3 first pulse width", highCnt, 21);

    // R2 R3 R8: table walk
    for (int v = 0; v < 6; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      measure(firstLow, highCnt, periodCnt);
      check(highCnt == VEC[v][4], "R3 R8 high time", highCnt, VEC[v][4]);
      check(periodCnt == VEC[v][5], "R2 period", periodCnt, VEC[v][5]);
      check(firstLow == VEC[v][5] - 1, "R7 first period low", firstLow, VEC[v][5] - 1);
    end

    // R4: zero duty never rises
    setup(0, 3, 0, 0);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwmOut) cnt++;
    end
    check(cnt == 0, "R4 zero duty high clocks", cnt, 0);

    // R5: duty equal to the full count and the maximum code stay high
    for (int k = 0; k < 2; k++) begin
      if (k == 0) setup(0, 9, 10, 0);
      else        setup(0, 9, 255, 3);
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      enable = 1'b1;
      waitRise(firstLow);
      check(firstLow == 39, "R5 first rise", firstLow, 39);
      cnt = 0;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        if (!pwmOut) cnt++;
      end
      check(cnt == 0, "R5 low clocks with full duty", cnt, 0);
    end

    // R6: mid-period rewrite waits for the boundary
    setup(0, 9, 5, 0);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitRise(firstLow);
    highCnt = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (highCnt == 5) dutyHigh = 8'd1;
      if (!pwmOut) break;
      highCnt++;
    end
    check(highCnt == 20, "R6 current period unchanged", highCnt, 20);
    waitRise(firstLow);
    countHigh(highCnt);
    check(highCnt == 4, "R6 next period uses new duty", highCnt, 4);

    // R7: disable mid-pulse, then restart
    waitRise(firstLow);
    enable = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R7 low one clock after disable", int'(pwmOut), 0);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwmOut) cnt++;
    end
    check(cnt == 0, "R7 held low while disabled", cnt, 0);
    enable = 1'b1;
    waitRise(firstLow);
    check(firstLow == 39, "R7 restart first period low", firstLow, 39);
    countHigh(highCnt);
    check(highCnt == 4, "R7 restart pulse width", highCnt, 4);

    // R8: one step of the low part at prescale 1 moves the edge by one clock
    setup(0, 9, 5, 2);
    measure(firstLow, highCnt, periodCnt);
    check(highCnt == 22, "R8 single-clock resolution", highCnt, 22);

    summary();
  end
endmodule